// File: doc/BRIEF.md
# Modbus RTU Frame Receiver

This block sits behind an existing byte-level serial receiver. It turns the received bytes into Modbus RTU messages. Frame boundaries come only from silence on the line. A byte that arrives after the line has been quiet for the programmed gap opens a new message. A byte that arrives sooner is appended to the current one. Once the gap has elapsed after the last byte, the message is closed.

The first byte of each message is compared with the station address. Messages for another station are swallowed silently. Accepted messages are passed downstream byte by byte on a valid/last stream. One cycle after the last byte, a status word reports:
- whether the CRC-16 came out clean,
- whether the message was long enough,
- whether any byte carried a parity error,
- whether it was a broadcast,
- how many bytes it held.

The gap is a count of clock cycles, normally 3.5 character times. At high line rates, a fixed floor applies instead. While the serial receiver reports a character in progress, the silence count is held at zero.

Top module: `mbrx_frame_rx`

## Requirements
- R1: After reset, no byte is accepted until the line has been silent for the effective gap. A byte arriving earlier is discarded and restarts the wait.
- R2: The effective gap G is `gap_cycles`, or `MIN_GAP` (default 8) when `gap_cycles` is smaller.
- R3: Let a byte be strobed at clock edge k. A following byte at edge k+d is appended to the same message when d <= G. A message interrupted by a longer pause is closed and reported as it stands.
- R4: The last byte of a message appears on the stream with `out_last` high after edge k+G+1, where k is its own strobe edge. `stat_vld` is high exactly one cycle later.
- R5: A message is accepted only when its first byte equals `station_addr` or 0x00. Any other message produces no stream byte and no status.
- R6: An accepted message's bytes appear on the stream in arrival order, all of them, including the address and the two CRC bytes.
- R7: The CRC is reflected polynomial 0xA001 with start value 0xFFFF, processed LSB first. The CRC low byte is sent first. `stat_flags[0]` is set when the CRC over all bytes, including the CRC field, is not zero.
- R8: `stat_flags[1]` is set when the message holds fewer than 4 bytes.
- R9: `stat_flags[2]` is set when any byte of the message arrived with `rx_par_err` high.
- R10: `stat_flags[3]` is set when the address byte was 0x00. `stat_good` is high exactly when bits 0 to 2 are all clear. `stat_len` is the byte count, saturating at its maximum.
- R11: While `rx_line_idle` is low, the silence count stays at zero. The gap is then measured from the cycle the line goes idle again.
- R12: Suppose a byte is strobed in the very cycle the gap completes (d = G+1). The previous message is closed and reported, and that byte opens the next message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_vld | input | 1 | One-cycle strobe: a received byte is present |
| rx_data | input | 8 | Received byte |
| rx_par_err | input | 1 | Parity error on the strobed byte |
| rx_line_idle | input | 1 | High when no character is being shifted in |
| gap_cycles | input | CNT_W | Silence threshold in clock cycles |
| station_addr | input | 8 | Local station address |
| out_vld | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of the message |
| stat_vld | output | 1 | Status word valid for one cycle |
| stat_good | output | 1 | Message free of errors |
| stat_flags | output | 4 | {broadcast, parity, short, crc} |
| stat_len | output | LEN_W | Byte count of the message |

## Verification
Two events can land in the same clock cycle: the silence timer reaching the gap, and a new byte strobe. The bench places a byte exactly G+1 edges after the previous one. It expects two separate messages, each with its own good status, and the second message's address byte must be the first stream byte after the first `out_last`. One edge earlier, at d = G, the same stimulus must give a single merged message. Together these two cases pin the boundary on both sides.

// File: rtl/mbrx_pkg.sv
package mbrx_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_ON   = 2'd2,
    ST_OFF  = 2'd3
  } rx_state_t;

  localparam int FLAG_CRC   = 0;
  localparam int FLAG_SHORT = 1;
  localparam int FLAG_PAR   = 2;
  localparam int FLAG_BCAST = 3;
  localparam int MIN_FRAME  = 4;
  localparam logic [7:0] BCAST_ADDR = 8'h00;
  localparam logic [15:0] CRC_INIT  = 16'hFFFF;
endpackage

// File: rtl/mbrx_crc16_byte.sv
module mbrx_crc16_byte #(
  parameter logic [15:0] POLY = 16'hA001
) (
  input  logic [15:0] crc_in,
  input  logic [7:0]  data,
  output logic [15:0] crc_out
);
  logic [15:0] stage [0:8];

  assign stage[0] = crc_in ^ {8'h00, data};

  for (genvar i = 0; i < 8; i++) begin : g_bit
    assign stage[i+1] = stage[i][0] ? ((stage[i] >> 1) ^ POLY) : (stage[i] >> 1);
  end

  assign crc_out = stage[8];
endmodule

// File: rtl/mbrx_gap_timer.sv
module mbrx_gap_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             line_idle,
  input  logic [CNT_W-1:0] thr,
  output logic             quiet
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (byte_vld || !line_idle) begin
      cnt_d = '0;
    end else if (cnt_q < thr) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign quiet = (cnt_q >= thr);

  assert_quiet_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && thr != '0) |=> !quiet);

  assert_busy_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_idle && thr != '0) |=> !quiet);
endmodule

// File: rtl/mbrx_frame_rx.sv
module mbrx_frame_rx
  import mbrx_pkg::*;
#(
  parameter int          CNT_W   = 16,
  parameter int          MIN_GAP = 8,
  parameter int          LEN_W   = 9,
  parameter logic [15:0] POLY    = 16'hA001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_vld,
  input  logic [7:0]       rx_data,
  input  logic             rx_par_err,
  input  logic             rx_line_idle,
  input  logic [CNT_W-1:0] gap_cycles,
  input  logic [7:0]       station_addr,
  output logic             out_vld,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             stat_vld,
  output logic             stat_good,
  output logic [3:0]       stat_flags,
  output logic [LEN_W-1:0] stat_len
);
  localparam logic [CNT_W-1:0] MIN_THR = CNT_W'(MIN_GAP);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_FRAME);

  rx_state_t        state_q, state_d;
  logic [15:0]      crc_q, crc_d, crc_seed, crc_next;
  logic [LEN_W-1:0] len_q, len_d;
  logic             par_q, par_d;
  logic             bcast_q, bcast_d;
  logic [7:0]       hold_q, hold_d;
  logic [7:0]       out_data_d;
  logic             out_vld_d, out_last_d;
  logic             stat_good_d;
  logic [3:0]       stat_flags_d;
  logic [LEN_W-1:0] stat_len_d;

  logic [CNT_W-1:0] thr_eff;
  logic             quiet, in_frame, frame_start, frame_add, frame_end;
  logic             addr_hit, emit_mid, emit_end;

  assign thr_eff = (gap_cycles < MIN_THR) ? MIN_THR : gap_cycles;

  mbrx_gap_timer #(.CNT_W(CNT_W)) u_gap (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (rx_vld),
    .line_idle (rx_line_idle),
    .thr       (thr_eff),
    .quiet     (quiet)
  );

  assign crc_seed = frame_start ? CRC_INIT : crc_q;

  mbrx_crc16_byte #(.POLY(POLY)) u_crc (
    .crc_in  (crc_seed),
    .data    (rx_data),
    .crc_out (crc_next)
  );

  assign in_frame    = (state_q == ST_ON) || (state_q == ST_OFF);
  assign frame_start = rx_vld && (quiet || state_q == ST_IDLE);
  assign frame_add   = rx_vld && !frame_start && in_frame;
  assign frame_end   = in_frame && quiet;
  assign addr_hit    = (rx_data == station_addr) || (rx_data == BCAST_ADDR);
  assign emit_mid    = frame_add && (state_q == ST_ON);
  assign emit_end    = frame_end && (state_q == ST_ON);

  always_comb begin
    state_d      = state_q;
    crc_d        = crc_q;
    len_d        = len_q;
    par_d        = par_q;
    bcast_d      = bcast_q;
    hold_d       = hold_q;
    out_vld_d    = emit_mid || emit_end;
    out_last_d   = emit_end;
    out_data_d   = out_data;
    stat_good_d  = stat_good;
    stat_flags_d = stat_flags;
    stat_len_d   = stat_len;

    if (frame_start) begin
      state_d = addr_hit ? ST_ON : ST_OFF;
    end else if (frame_end) begin
      state_d = ST_IDLE;
    end else if (state_q == ST_WAIT && quiet) begin
      state_d = ST_IDLE;
    end

    if (frame_start || frame_add) begin
      crc_d  = crc_next;
      hold_d = rx_data;
      par_d  = frame_start ? rx_par_err : (par_q | rx_par_err);
    end
    if (frame_start) begin
      len_d   = LEN_W'(1);
      bcast_d = (rx_data == BCAST_ADDR);
    end else if (frame_add && len_q != LEN_MAX) begin
      len_d = len_q + 1'b1;
    end

    if (out_vld_d) begin
      out_data_d = hold_q;
    end
    if (emit_end) begin
      stat_flags_d[FLAG_CRC]   = (crc_q != 16'h0000);
      stat_flags_d[FLAG_SHORT] = (len_q < LEN_MIN);
      stat_flags_d[FLAG_PAR]   = par_q;
      stat_flags_d[FLAG_BCAST] = bcast_q;
      stat_good_d = (crc_q == 16'h0000) && (len_q >= LEN_MIN) && !par_q;
      stat_len_d  = len_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_WAIT;
      crc_q      <= CRC_INIT;
      len_q      <= '0;
      par_q      <= 1'b0;
      bcast_q    <= 1'b0;
      hold_q     <= '0;
      out_vld    <= 1'b0;
      out_last   <= 1'b0;
      out_data   <= '0;
      stat_vld   <= 1'b0;
      stat_good  <= 1'b0;
      stat_flags <= '0;
      stat_len   <= '0;
    end else begin
      state_q    <= state_d;
      crc_q      <= crc_d;
      len_q      <= len_d;
      par_q      <= par_d;
      bcast_q    <= bcast_d;
      hold_q     <= hold_d;
      out_vld    <= out_vld_d;
      out_last   <= out_last_d;
      out_data   <= out_data_d;
      stat_vld   <= out_vld && out_last;
      stat_good  <= stat_good_d;
      stat_flags <= stat_flags_d;
      stat_len   <= stat_len_d;
    end
  end

  assert_status_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_last) |=> stat_vld);

  assert_status_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld |-> $past(out_vld && out_last));

  assert_only_addressed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(state_q == ST_ON));

  assert_append_inside_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_last) |-> $past(!quiet));
endmodule

// File: tb/tb_mbrx_frame_rx.sv
module tb_mbrx_frame_rx;
  localparam int THR = 20;
  localparam logic [7:0] MY_ADDR = 8'h11;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_vld, rx_par_err, rx_line_idle;
  logic [7:0]  rx_data, station_addr;
  logic [15:0] gap_cycles;
  logic        out_vld, out_last, stat_vld, stat_good;
  logic [7:0]  out_data;
  logic [3:0]  stat_flags;
  logic [8:0]  stat_len;

  always #2 clk = ~clk;

  mbrx_frame_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_data(rx_data),
    .rx_par_err(rx_par_err), .rx_line_idle(rx_line_idle),
    .gap_cycles(gap_cycles), .station_addr(station_addr),
    .out_vld(out_vld), .out_data(out_data), .out_last(out_last),
    .stat_vld(stat_vld), .stat_good(stat_good), .stat_flags(stat_flags),
    .stat_len(stat_len)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int thr = THR;
  int strobe_cyc;
  logic [7:0] fb [0:63];

  int         rx_n = 0, st_n = 0, last_cyc = 0;
  logic [7:0] rx_b [0:255];
  logic       st_good_a [0:31];
  logic [3:0] st_flag_a [0:31];
  int         st_len_a [0:31];
  int         st_cyc_a [0:31];

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_vld) begin
        if (rx_n < 256) rx_b[rx_n] = out_data;
        rx_n = rx_n + 1;
        if (out_last) last_cyc = cyc;
      end
      if (stat_vld) begin
        if (st_n < 32) begin
          st_good_a[st_n] = stat_good;
          st_flag_a[st_n] = stat_flags;
          st_len_a[st_n]  = int'(stat_len);
          st_cyc_a[st_n]  = cyc;
        end
        st_n = st_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_of(input int base, input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, fb[base+i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [3:0] exp_flags(input int base, input int n, input bit pe);
    return {fb[base] == 8'h00, pe, n < 4, crc_of(base, n) != 16'h0000};
  endfunction

  task automatic build(input int base, input logic [7:0] addr, input int ndata, input logic [7:0] seed);
    logic [15:0] c;
    fb[base]   = addr;
    fb[base+1] = 8'h03;
    for (int j = 0; j < ndata; j++) fb[base+2+j] = seed + 8'(j * 7);
    c = crc_of(base, ndata + 2);
    fb[base+ndata+2] = c[7:0];
    fb[base+ndata+3] = c[15:8];
  endtask

  task automatic put(input logic [7:0] b, input bit pe);
    rx_vld = 1'b1; rx_data = b; rx_par_err = pe;
    @(negedge clk);
    strobe_cyc = cyc;
    rx_vld = 1'b0; rx_par_err = 1'b0;
  endtask

  task automatic send(input int base, input int n, input int d, input int gap_idx,
                      input int gap_d, input int pe_idx);
    for (int i = 0; i < n; i++) begin
      if (i > 0) repeat (((i == gap_idx) ? gap_d : d) - 1) @(negedge clk);
      put(fb[base+i], i == pe_idx);
    end
  endtask

  task automatic settle();
    repeat (thr + 8) @(negedge clk);
  endtask

  task automatic check_one(input int rb, input int sb, input int base, input int n,
                           input bit pe, input string req);
    int bad = 0;
    logic [3:0] ef;
    ef = exp_flags(base, n, pe);
    chk(rx_n - rb == n, {req, " byte count"}, rx_n - rb, n);
    for (int i = 0; i < n; i++) if (rx_b[rb+i] !== fb[base+i]) bad++;
    chk(bad == 0, {req, " R6 byte order"}, bad, 0);
    chk(st_n - sb == 1, {req, " status count"}, st_n - sb, 1);
    chk(st_flag_a[sb] == ef, {req, " flags"}, st_flag_a[sb], ef);
    chk(st_good_a[sb] == (ef[2:0] == 3'b000), {req, " R10 good"}, st_good_a[sb], ef[2:0] == 3'b000);
    chk(st_len_a[sb] == n, {req, " R10 length"}, st_len_a[sb], n);
  endtask

  task automatic t_reset();
    chk(out_vld == 1'b0 && stat_vld == 1'b0, "R1 reset outputs", {out_vld, stat_vld}, 0);
  endtask

  task automatic t_early_after_reset();
    int rb = rx_n, sb = st_n;
    build(0, MY_ADDR, 2, 8'h20);
    send(0, 6, 2, -1, 0, -1);
    settle();
    chk(rx_n == rb && st_n == sb, "R1 bytes before quiet discarded", rx_n - rb, 0);
  endtask

  task automatic t_good_frame();
    int rb = rx_n, sb = st_n;
    build(0, MY_ADDR, 4, 8'h00);
    send(0, 8, 1, -1, 0, -1);
    settle();
    check_one(rb, sb, 0, 8, 0, "R7 good frame");
    chk(last_cyc - strobe_cyc == thr + 1, "R4 last timing", last_cyc - strobe_cyc, thr + 1);
    chk(st_cyc_a[sb] - last_cyc == 1, "R4 status timing", st_cyc_a[sb] - last_cyc, 1);
  endtask

  task automatic t_bad_crc();
    int rb = rx_n, sb = st_n;
    build(0, MY_ADDR, 3, 8'h55);
    fb[3] = fb[3] ^ 8'h40;
    send(0, 7, 1, -1, 0, -1);
    settle();
    check_one(rb, sb, 0, 7, 0, "R7 bad crc");
  endtask

  task automatic t_short();
    int rb = rx_n, sb = st_n;
    build(0, MY_ADDR, 2, 8'h10);
    send(0, 3, 1, -1, 0, -1);
    settle();
    check_one(rb, sb, 0, 3, 0, "R8 short frame");
  endtask

  task automatic t_parity();
    int rb = rx_n, sb = st_n;
    build(0, MY_ADDR, 2, 8'h33);
    send(0, 6, 3, -1, 0, 2);
    settle();
    check_one(rb, sb, 0, 6, 1, "R9 parity");
  endtask

  task automatic t_broadcast();
    int rb = rx_n, sb = st_n;
    build(0, 8'h00, 2, 8'h44);
    send(0, 6, 1, -1, 0, -1);
    settle();
    check_one(rb, sb, 0, 6, 0, "R5 R10 broadcast");
  endtask

  task automatic t_other_addr();
    int rb = rx_n, sb = st_n;
    build(0, 8'h22, 2, 8'h66);
    send(0, 6, 1, -1, 0, -1);
    settle();
    chk(rx_n == rb && st_n == sb, "R5 foreign address dropped", rx_n - rb + st_n - sb, 0);
  endtask

  task automatic t_append_at_gap();
    int rb = rx_n, sb = st_n;
    build(16, MY_ADDR, 4, 8'h70);
    send(16, 8, 1, 4, thr, -1);
    settle();
    check_one(rb, sb, 16, 8, 0, "R3 append at d=G");
  endtask

  task automatic t_split_same_cycle();
    int rb = rx_n, sb = st_n;
    build(0, MY_ADDR, 2, 8'h01);
    build(8, MY_ADDR, 1, 8'h90);
    send(0, 6, 1, -1, 0, -1);
    repeat (thr) @(negedge clk);
    send(8, 5, 1, -1, 0, -1);
    settle();
    chk(st_n - sb == 2, "R12 two statuses", st_n - sb, 2);
    chk(rx_n - rb == 11, "R12 total bytes", rx_n - rb, 11);
    chk(st_good_a[sb] && st_len_a[sb] == 6, "R12 first frame", st_len_a[sb], 6);
    chk(st_good_a[sb+1] && st_len_a[sb+1] == 5, "R12 second frame", st_len_a[sb+1], 5);
    chk(rx_b[rb+6] == fb[8], "R12 new address byte", rx_b[rb+6], fb[8]);
  endtask

  task automatic t_flush_partial();
    int rb = rx_n, sb = st_n;
    build(0, MY_ADDR, 2, 8'hA0);
    send(0, 3, 1, -1, 0, -1);
    repeat (thr + 5) @(negedge clk);
    send(0, 6, 1, -1, 0, -1);
    settle();
    chk(st_n - sb == 2, "R3 flush gives two statuses", st_n - sb, 2);
    chk(st_flag_a[sb] == exp_flags(0, 3, 0), "R3 partial flagged", st_flag_a[sb], exp_flags(0, 3, 0));
    chk(st_good_a[sb+1] && st_len_a[sb+1] == 6, "R3 restart good", st_len_a[sb+1], 6);
    chk(rx_n - rb == 9, "R3 byte total", rx_n - rb, 9);
  endtask

  task automatic t_min_gap();
    int sb;
    gap_cycles = 16'd3;
    thr = 8;
    settle();
    sb = st_n;
    build(0, MY_ADDR, 1, 8'h12);
    send(0, 5, 1, -1, 0, -1);
    settle();
    chk(last_cyc - strobe_cyc == 9, "R2 floor timing", last_cyc - strobe_cyc, 9);
    chk(st_n - sb == 1 && st_good_a[sb], "R2 floor frame good", st_n - sb, 1);
    gap_cycles = 16'(THR);
    thr = THR;
    settle();
  endtask

  task automatic t_line_busy();
    int sb = st_n, lstart;
    build(0, MY_ADDR, 2, 8'h5A);
    send(0, 6, 1, -1, 0, -1);
    rx_line_idle = 1'b0;
    repeat (40) @(negedge clk);
    chk(st_n == sb, "R11 no end while busy", st_n - sb, 0);
    rx_line_idle = 1'b1;
    lstart = cyc + 1;
    settle();
    chk(last_cyc == lstart + thr, "R11 gap from idle", last_cyc - lstart, thr);
    chk(st_n - sb == 1 && st_good_a[sb], "R11 frame reported", st_n - sb, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    rx_vld = 1'b0; rx_data = 8'h00; rx_par_err = 1'b0; rx_line_idle = 1'b1;
    gap_cycles = 16'(THR);
    station_addr = MY_ADDR;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_early_after_reset();
    t_good_frame();
    t_bad_crc();
    t_short();
    t_parity();
    t_broadcast();
    t_other_addr();
    t_append_at_gap();
    t_split_same_cycle();
    t_flush_partial();
    t_min_gap();
    t_line_busy();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule